// File: doc/BRIEF.md
# Chunk Log Packet Generator

This block sits beside a core's retirement logic in a deterministic-replay recorder. It splits the execution of a thread into chunks. For each chunk it counts the instructions that retire. It also tracks how many memory micro-operations of the instruction still in flight have already retired. When a chunk ends, it records how many stores are still waiting in the store buffer. A chunk ends when an external conflict or system-event detector raises a termination request, or when the chunk-size counter fills. At that point the block writes a 128-bit chunk record onto a valid/ready stream.

Chunk records carry time as an offset from the last absolute timestamp the stream emitted. If no absolute timestamp has been emitted yet, or the offset no longer fits its field, the block first emits a 128-bit absolute-timestamp record and then the chunk record, whose offset is zero. After the chunk record is accepted, the block pulses a clear to the external read/write-set filters.

Top module: `chunk_log_gen`

## Requirements
- R1: After reset, `pkt_valid_o`, `set_clear_o` and `term_ack_o` are low. The first chunk after reset is always preceded by an absolute-timestamp record.
- R2: The logged chunk size is the number of cycles with `retire_i` high since the previous capture, counting the capture cycle itself. The counter restarts from zero after each capture.
- R3: When the count including the current cycle reaches 2^CS_W-1, the chunk is captured without a request, with reason code 6 (size overflow). Its logged size is 2^CS_W-1.
- R4: The atomicity count adds 1 for each retired split-line memory micro-op and 2 for any other retired memory micro-op. It becomes 0 in a cycle where `retire_i` is high, and that reset takes precedence. Chunk capture does not reset it, so an odd value can be logged and can carry on into the next chunk. The value after the capture cycle's update is logged.
- R5: The value of `pend_st_i` in the capture cycle is logged in bits 59..63 of the chunk record.
- R6: Chunk record layout: format 0 in bits 0..2, reason in 3..6, time offset in 7..38, size in 39..58, pending stores in 59..63, atomicity count in 64..79, zero in 80..127. Reason codes are 0 read-after-write, 1 write-after-read, 2 write-after-write, 3 write-after-both, 4 exception, 5 eviction hit, 6 size overflow, 7 TLB invalidation, 8 explicit termination.
- R7: Timestamp record layout: format 1 in bits 0..2, the 64-bit absolute time in 7..70, all other bits zero.
- R8: The time offset is `ts_i` at capture minus the last absolute time emitted. When no absolute time has been emitted yet, or the offset is at least 2^DELTA_W, a timestamp record carrying `ts_i` is emitted first. The chunk record that follows it carries offset 0.
- R9: While `pkt_valid_o` is high and `pkt_ready_i` is low, `pkt_valid_o` and `pkt_data_o` hold.
- R10: `set_clear_o` is high for exactly the one cycle after a chunk record is accepted.
- R11: If an external request and the size-overflow condition coincide, one chunk is captured with the requested reason, and its logged size is 2^CS_W-1.
- R12: `term_ack_o` is high exactly when the block is idle and `term_req_i` is high. A request made while a record is pending is not acknowledged and produces no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| retire_i | input | 1 | Instruction retired this cycle |
| mem_retire_i | input | 1 | Memory micro-op retired this cycle |
| mem_split_i | input | 1 | That micro-op is one half of a split-line access |
| pend_st_i | input | RSW_W | Stores pending in the store buffer |
| ts_i | input | 64 | Global timestamp |
| term_req_i | input | 1 | Chunk termination request, held until acknowledged |
| term_reason_i | input | 4 | Reason code of the request |
| term_ack_o | output | 1 | Request captured this cycle |
| pkt_valid_o | output | 1 | Record available |
| pkt_ready_i | input | 1 | Consumer accepts the record |
| pkt_data_o | output | 128 | Record contents |
| set_clear_o | output | 1 | Clear pulse for the read/write-set filters |

## Verification
Two functions can fall in the same cycle: an external termination request and the size counter's own overflow trigger. The bench provokes this by retiring instructions up to one below the limit and then raising a request together with a final retirement. It expects exactly one chunk record carrying the requested reason and the saturated size, and no second overflow record. A second coincidence is tested the same way: an instruction retirement together with a memory micro-op in a capture cycle, where the atomicity count must be logged as zero.

// File: rtl/chunk_log_pkg.sv
package chunk_log_pkg;
  localparam int PKT_W  = 128;
  localparam int TS_W   = 64;
  localparam int FMT_LO = 0;
  localparam int RSN_LO = 3;
  localparam int DLT_LO = 7;
  localparam int CS_LO  = 39;
  localparam int RSW_LO = 59;
  localparam int IAV_LO = 64;
  localparam int ABS_LO = 7;

  localparam logic [2:0] FMT_CHUNK = 3'd0;
  localparam logic [2:0] FMT_TIME  = 3'd1;

  typedef enum logic [3:0] {
    RSN_RAW, RSN_WAR, RSN_WAW, RSN_WAB, RSN_EXCEPT,
    RSN_EVICT, RSN_CS_OVF, RSN_TLBINV, RSN_XTC
  } reason_e;

  typedef enum logic [1:0] {ST_IDLE, ST_TIME, ST_CHUNK} emit_state_e;
endpackage

// File: rtl/chunk_ctr.sv
module chunk_ctr #(
  parameter int CS_W  = 20,
  parameter int IAV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             retire_i,
  input  logic             mem_i,
  input  logic             split_i,
  input  logic             capture_i,
  output logic [CS_W-1:0]  cs_snap_o,
  output logic             cs_full_o,
  output logic [IAV_W-1:0] iav_snap_o
);
  localparam logic [CS_W-1:0] CS_MAX = {CS_W{1'b1}};

  logic [CS_W-1:0]  cs_q;
  logic [IAV_W-1:0] iav_q, iav_step;

  assign cs_snap_o = (retire_i && cs_q != CS_MAX) ? cs_q + 1'b1 : cs_q;
  assign cs_full_o = (cs_snap_o == CS_MAX);
  assign iav_step  = mem_i ? (split_i ? IAV_W'(1) : IAV_W'(2)) : '0;
  assign iav_snap_o = retire_i ? '0 : iav_q + iav_step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q  <= '0;
      iav_q <= '0;
    end else begin
      cs_q  <= capture_i ? '0 : cs_snap_o;
      iav_q <= iav_snap_o;
    end
  end

  a_r2_cs_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> cs_q == '0);
  a_r4_iav_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_i |=> iav_q == '0);
  a_r4_iav_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!retire_i && !mem_i) |=> $stable(iav_q));
endmodule

// File: rtl/ts_track.sv
module ts_track
  import chunk_log_pkg::*;
#(
  parameter int DELTA_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [TS_W-1:0]    ts_i,
  input  logic               load_i,
  output logic [TS_W-1:0]    base_o,
  output logic [DELTA_W-1:0] delta_o,
  output logic               need_abs_o
);
  logic [TS_W-1:0] base_q, diff;
  logic            vld_q;

  assign diff       = ts_i - base_q;
  assign delta_o    = diff[DELTA_W-1:0];
  assign need_abs_o = !vld_q || (diff[TS_W-1:DELTA_W] != '0);
  assign base_o     = base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      vld_q  <= 1'b0;
    end else if (load_i) begin
      base_q <= ts_i;
      vld_q  <= 1'b1;
    end
  end

  a_r8_base_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> vld_q && base_q == $past(ts_i));
endmodule

// File: rtl/pkt_emit.sv
module pkt_emit
  import chunk_log_pkg::*;
#(
  parameter int CS_W    = 20,
  parameter int IAV_W   = 16,
  parameter int RSW_W   = 5,
  parameter int DELTA_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               term_req_i,
  input  logic [3:0]         reason_i,
  input  logic               cs_full_i,
  input  logic [CS_W-1:0]    cs_snap_i,
  input  logic [IAV_W-1:0]   iav_snap_i,
  input  logic [RSW_W-1:0]   rsw_i,
  input  logic               need_abs_i,
  input  logic [DELTA_W-1:0] delta_i,
  input  logic [TS_W-1:0]    base_i,
  input  logic               ready_i,
  output logic               capture_o,
  output logic               load_abs_o,
  output logic               ack_o,
  output logic               valid_o,
  output logic [PKT_W-1:0]   data_o,
  output logic               clear_o
);
  emit_state_e        st_q;
  logic [3:0]         rsn_q;
  logic [CS_W-1:0]    cs_q;
  logic [IAV_W-1:0]   iav_q;
  logic [RSW_W-1:0]   rsw_q;
  logic [DELTA_W-1:0] dlt_q;
  logic               clr_q, idle, hs;
  logic [PKT_W-1:0]   chunk_pkt, time_pkt;

  assign idle       = (st_q == ST_IDLE);
  assign capture_o  = idle && (term_req_i || cs_full_i);
  assign ack_o      = idle && term_req_i;
  assign load_abs_o = capture_o && need_abs_i;
  assign valid_o    = !idle;
  assign hs         = valid_o && ready_i;
  assign clear_o    = clr_q;

  always_comb begin
    chunk_pkt = '0;
    chunk_pkt[FMT_LO +: 3]       = FMT_CHUNK;
    chunk_pkt[RSN_LO +: 4]       = rsn_q;
    chunk_pkt[DLT_LO +: DELTA_W] = dlt_q;
    chunk_pkt[CS_LO +: CS_W]     = cs_q;
    chunk_pkt[RSW_LO +: RSW_W]   = rsw_q;
    chunk_pkt[IAV_LO +: IAV_W]   = iav_q;
    time_pkt = '0;
    time_pkt[FMT_LO +: 3]        = FMT_TIME;
    time_pkt[ABS_LO +: TS_W]     = base_i;
  end

  assign data_o = (st_q == ST_TIME) ? time_pkt : chunk_pkt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      rsn_q <= '0;
      cs_q  <= '0;
      iav_q <= '0;
      rsw_q <= '0;
      dlt_q <= '0;
      clr_q <= 1'b0;
    end else begin
      clr_q <= hs && (st_q == ST_CHUNK);
      unique case (st_q)
        ST_IDLE: if (capture_o) begin
          rsn_q <= term_req_i ? reason_i : RSN_CS_OVF;  // request wins over overflow
          cs_q  <= cs_snap_i;
          iav_q <= iav_snap_i;
          rsw_q <= rsw_i;
          dlt_q <= need_abs_i ? '0 : delta_i;
          st_q  <= need_abs_i ? ST_TIME : ST_CHUNK;
        end
        ST_TIME:  if (hs) st_q <= ST_CHUNK;
        ST_CHUNK: if (hs) st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> valid_o && $stable(data_o));
  a_r8_time_then_chunk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs && data_o[FMT_LO +: 3] == FMT_TIME) |=> valid_o && data_o[FMT_LO +: 3] == FMT_CHUNK);
  a_r10_clear_after_chunk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_o |-> $past(hs && data_o[FMT_LO +: 3] == FMT_CHUNK));
  a_r12_no_ack_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !ack_o);
endmodule

// File: rtl/chunk_log_gen.sv
module chunk_log_gen
  import chunk_log_pkg::*;
#(
  parameter int CS_W    = 20,
  parameter int IAV_W   = 16,
  parameter int RSW_W   = 5,
  parameter int DELTA_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             retire_i,
  input  logic             mem_retire_i,
  input  logic             mem_split_i,
  input  logic [RSW_W-1:0] pend_st_i,
  input  logic [63:0]      ts_i,
  input  logic             term_req_i,
  input  logic [3:0]       term_reason_i,
  output logic             term_ack_o,
  output logic             pkt_valid_o,
  input  logic             pkt_ready_i,
  output logic [127:0]     pkt_data_o,
  output logic             set_clear_o
);
  logic               capture, load_abs, cs_full, need_abs;
  logic [CS_W-1:0]    cs_snap;
  logic [IAV_W-1:0]   iav_snap;
  logic [DELTA_W-1:0] delta;
  logic [TS_W-1:0]    base;

  chunk_ctr #(.CS_W(CS_W), .IAV_W(IAV_W)) u_ctr (
    .clk_i, .rst_ni,
    .retire_i, .mem_i(mem_retire_i), .split_i(mem_split_i),
    .capture_i(capture),
    .cs_snap_o(cs_snap), .cs_full_o(cs_full), .iav_snap_o(iav_snap)
  );

  ts_track #(.DELTA_W(DELTA_W)) u_ts (
    .clk_i, .rst_ni, .ts_i, .load_i(load_abs),
    .base_o(base), .delta_o(delta), .need_abs_o(need_abs)
  );

  pkt_emit #(.CS_W(CS_W), .IAV_W(IAV_W), .RSW_W(RSW_W), .DELTA_W(DELTA_W)) u_emit (
    .clk_i, .rst_ni,
    .term_req_i, .reason_i(term_reason_i),
    .cs_full_i(cs_full), .cs_snap_i(cs_snap), .iav_snap_i(iav_snap),
    .rsw_i(pend_st_i), .need_abs_i(need_abs), .delta_i(delta), .base_i(base),
    .ready_i(pkt_ready_i),
    .capture_o(capture), .load_abs_o(load_abs), .ack_o(term_ack_o),
    .valid_o(pkt_valid_o), .data_o(pkt_data_o), .clear_o(set_clear_o)
  );
endmodule

// File: tb/chunk_log_gen_bench.sv
`timescale 1ns/1ps
module chunk_log_gen_bench;
  localparam int CS_W = 4, IAV_W = 16, RSW_W = 5, DELTA_W = 8;
  localparam int CS_MAX = (1 << CS_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic retire = 0, mem = 0, split = 0, req = 0, ready = 0;
  logic [RSW_W-1:0] pend = '0;
  logic [63:0] ts = '0;
  logic [3:0] rsn = '0;
  logic ack, valid, clr;
  logic [127:0] data;

  always #2.5 clk = ~clk;

  chunk_log_gen #(.CS_W(CS_W), .IAV_W(IAV_W), .RSW_W(RSW_W), .DELTA_W(DELTA_W)) u_chunk_log_gen (
    .clk_i(clk), .rst_ni(rst_n), .retire_i(retire), .mem_retire_i(mem), .mem_split_i(split),
    .pend_st_i(pend), .ts_i(ts), .term_req_i(req), .term_reason_i(rsn), .term_ack_o(ack),
    .pkt_valid_o(valid), .pkt_ready_i(ready), .pkt_data_o(data), .set_clear_o(clr)
  );

  int n_chk = 0, n_fail = 0;
  int m_cs = 0, m_iav = 0;
  bit m_bvld = 0;
  logic [63:0] m_base = '0, ts_now = 64'd1000;
  logic [127:0] e_time, e_chunk;
  bit e_two;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one input cycle; returns whether a capture is expected at this edge
  task automatic cyc(input bit r, input bit m, input bit s, input bit t,
                     input int rs, input int ps, output bit cap);
    int cs_n, exp_rsn;
    logic [63:0] diff;
    @(negedge clk);
    retire = r; mem = m; split = s; req = t; rsn = 4'(rs); pend = RSW_W'(ps); ts = ts_now;
    m_iav = r ? 0 : ((m_iav + (m ? (s ? 1 : 2) : 0)) & 16'hffff);
    cs_n = (r && m_cs < CS_MAX) ? m_cs + 1 : m_cs;
    cap = t || (cs_n == CS_MAX);
    #1;
    chk(ack == t, "R12 ack", 128'(ack), 128'(t));
    if (cap) begin
      exp_rsn = t ? rs : 6;
      diff = ts_now - m_base;
      e_two = !m_bvld || (diff >= 64'(1 << DELTA_W));
      if (e_two) begin
        m_base = ts_now; m_bvld = 1; diff = '0;
        e_time = '0; e_time[2:0] = 3'd1; e_time[70:7] = ts_now;
      end
      e_chunk = '0;
      e_chunk[6:3] = 4'(exp_rsn);
      e_chunk[38:7] = 32'(diff);
      e_chunk[58:39] = 20'(cs_n);
      e_chunk[63:59] = 5'(ps);
      e_chunk[79:64] = 16'(m_iav);
      m_cs = 0;
    end else m_cs = cs_n;
    @(posedge clk);
    ts_now = ts_now + 1;
  endtask

  task automatic take(input logic [127:0] exp, input int stall, input bit busy_req, input string tag);
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      ready = 0; retire = 0; mem = 0; split = 0; req = busy_req; rsn = 4'd8;
      #1;
      chk(valid && data == exp, "R9 held while stalled", data, exp);
      if (busy_req) chk(!ack, "R12 no ack while busy", 128'(ack), 128'(0));
    end
    @(negedge clk);
    ready = 1; retire = 0; mem = 0; split = 0; req = 0;
    #1;
    chk(valid && data == exp, tag, data, exp);
    @(posedge clk);
  endtask

  task automatic drain(input int stall, input bit busy_req);
    if (e_two) take(e_time, stall, busy_req, "R7/R8 timestamp record");
    take(e_chunk, stall, busy_req, "R2/R5/R6 chunk record");
    @(negedge clk);
    ready = 0;
    #1;
    chk(clr == 1'b1, "R10 clear pulse", 128'(clr), 128'(1));
    @(negedge clk);
    #1;
    chk(clr == 1'b0 && valid == 1'b0, "R10/R12 idle after record", {clr, valid}, 128'(0));
  endtask

  bit cap;

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(!valid && !clr && !ack, "R1 reset state", {valid, clr, ack}, 128'(0));

    // R2 R4 R5 R6: sweep chunk lengths, reasons, stall lengths
    for (int n = 0; n < 14; n++) begin
      for (int i = 0; i < n; i++)
        cyc(i % 4 == 3, i % 3 != 0, i[0], 0, 0, 0, cap);
      cyc(n[0], 1, n % 3 == 0, 1, n % 9, (n * 7) % 32, cap);
      if (n == 0) chk(e_two, "R1 first chunk needs timestamp", 128'(e_two), 128'(1));
      drain(n % 3, n == 5);
    end

    // R3: overflow with no request
    cap = 0;
    for (int i = 0; i < 40 && !cap; i++) cyc(1, 0, 0, 0, 0, 3, cap);
    chk(e_chunk[6:3] == 4'd6 && e_chunk[58:39] == 20'(CS_MAX), "R3 model reason", e_chunk, e_chunk);
    drain(1, 0);

    // R11: request coincides with overflow
    for (int i = 0; i < CS_MAX - 1; i++) cyc(1, 0, 0, 0, 0, 0, cap);
    cyc(1, 0, 0, 1, 4, 9, cap);
    drain(0, 0);

    // R4: odd count logged, persists across chunks, reset on retire
    cyc(0, 1, 1, 1, 1, 2, cap); drain(0, 0);
    cyc(0, 1, 0, 1, 2, 2, cap); drain(2, 0);
    cyc(1, 1, 0, 1, 3, 2, cap); drain(0, 0);

    // R8: offset boundaries and large jumps
    ts_now = m_base + 255;
    cyc(0, 0, 0, 1, 7, 1, cap);
    chk(!e_two, "R8 offset 255 fits", 128'(e_two), 128'(0));
    drain(0, 0);
    ts_now = m_base + 256;
    cyc(0, 0, 0, 1, 8, 1, cap);
    chk(e_two, "R8 offset 256 overflows", 128'(e_two), 128'(1));
    drain(1, 0);
    ts_now = ts_now + 64'h0000_0123_0000_0000;
    cyc(1, 1, 1, 1, 5, 31, cap); drain(0, 0);
    cyc(0, 0, 0, 1, 0, 0, cap); drain(0, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule